// File: doc/BRIEF.md
# Configuration Stream Header Stripper

This block is a byte-stream filter that sits in front of a configuration loader. The file reaching it starts with a header. The header holds several variable-length fields, each preceded by a big-endian 16-bit length. Single key bytes separate some of the later fields. After the header comes a 32-bit byte count, and after that the configuration payload. The block walks through the header without storing it, checks each key byte, and captures the count. It then passes exactly that many payload bytes downstream and raises a completion flag.

The input and output each use a valid/ready handshake. While the header is being consumed, input is always accepted and nothing is presented downstream. During the payload the output is a direct combinational pass-through of the input, and the input ready follows the downstream ready, so no byte is lost or duplicated. A wrong key byte stops the block in an error state until reset.

Top module: `cfg_hdr_strip`

## Requirements
- R1: The header begins with six length-prefixed fields. Each field carries a 2-byte length, most significant byte first, followed by that many content bytes. Fields 0 and 1 follow each other directly. Fields 2, 3, 4 and 5 are each followed by one key byte.
- R2: A field whose length is zero has no content bytes. The next byte after its length is the next header element.
- R3: The four key bytes must equal 0x62, 0x63, 0x64 and 0x65 ('b' to 'e'), in that order. A mismatch raises `hdr_err` on the cycle after the bad byte is accepted. `hdr_err` stays high until reset, and after that `in_ready` and `out_valid` stay low.
- R4: The four bytes after the last key byte form the payload byte count, most significant byte first.
- R5: Payload bytes leave on `out_data` unchanged and in order. Exactly the counted number of bytes leave.
- R6: `out_valid` is never high while any header byte, key byte or count byte is being consumed.
- R7: During the payload `in_ready` equals `out_ready`. A payload byte offered while `out_ready` is low is held and is neither accepted nor dropped.
- R8: `done` rises on the cycle after the last payload byte is taken downstream. It then stays high, with `in_ready` low, until reset.
- R9: A payload count of zero raises `done` on the cycle after the last count byte is accepted, and no byte is forwarded.
- R10: After reset `in_ready` is high, and `out_valid`, `done` and `hdr_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 8 | Incoming stream byte |
| in_valid | input | 1 | Incoming byte is valid |
| in_ready | output | 1 | Block accepts the incoming byte |
| out_data | output | 8 | Forwarded payload byte |
| out_valid | output | 1 | Forwarded byte is valid |
| out_ready | input | 1 | Downstream accepts the forwarded byte |
| hdr_err | output | 1 | Key byte mismatch, sticky until reset |
| done | output | 1 | Whole payload delivered, sticky until reset |

## Verification
If the header walker loses its place, the fault shows at the ports within a few bytes. A misplaced key byte check raises `hdr_err` where none is expected. Alternatively, payload starts early or late, so the forwarded byte sequence differs from the expected one at its first byte. A wrong count shows as a payload that is too short or too long, and `done` rises at the wrong cycle. A break in the handshake coupling shows as a byte that was accepted while `out_ready` was low and never appears downstream. The bench compares every forwarded byte and its count against a reference built from the stream it generated. It also checks `done` and `in_ready` one cycle after the final transfer.

// File: rtl/cfg_hdr_strip_pkg.sv
// Package: shared constants and the walker step encoding for the header stripper.
// Assumes a byte-wide stream; all other widths are parameters of the modules.
package cfg_hdr_strip_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_LEN  = 3'd0,   // collecting a field length
        ST_BODY = 3'd1,   // skipping field content
        ST_KEY  = 3'd2,   // checking a key byte
        ST_SIZE = 3'd3,   // collecting the payload count
        ST_PAY  = 3'd4,   // forwarding payload
        ST_DONE = 3'd5,   // payload finished
        ST_ERR  = 3'd6    // malformed header
    } step_t;

endpackage

// File: rtl/cfg_hdr_down_cnt.sv
// Module: loadable down counter fed one byte at a time, most significant byte first.
// Assumes W is a multiple of 8 and at least 16, and that shift and decrement are
// never requested together. Reports "would be zero after this shift" and
// "one left" so the walker can branch without an extra cycle.
module cfg_hdr_down_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         dec_en,
    input  logic [7:0]   byte_in,
    output logic         shift_zero,
    output logic         cnt_last
);
    logic [W-1:0] cnt;
    logic [W-1:0] cnt_shifted;

    // Next value if the current byte is shifted in at the low end.
    always_comb cnt_shifted = {cnt[W-9:0], byte_in};

    // Flags used by the walker to decide the next step.
    always_comb begin
        shift_zero = (cnt_shifted == '0);
        cnt_last   = (cnt == W'(1));
    end

    // Counter register: byte load or single decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (shift_en) cnt <= cnt_shifted;
        else if (dec_en)   cnt <= cnt - W'(1);
    end

    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |-> (cnt != '0));

    a_r1_single_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_en && dec_en));

endmodule

// File: rtl/cfg_hdr_walker.sv
// Module: header walker. Steps through length-prefixed fields and key bytes,
// captures the payload count, and sequences payload and completion.
// Assumes the two counters report on their current byte combinationally.
module cfg_hdr_walker
    import cfg_hdr_strip_pkg::*;
#(
    parameter int         LEN_W     = 16,
    parameter int         SIZE_W    = 32,
    parameter int         NUM_PLAIN = 2,
    parameter int         NUM_KEYED = 4,
    parameter logic [7:0] KEY_BASE  = 8'h62
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    input  logic        out_ready,
    output logic        in_ready,
    output step_t       step,
    output logic        len_shift,
    output logic        len_dec,
    input  logic        len_zero,
    input  logic        len_last,
    output logic        size_shift,
    output logic        size_dec,
    input  logic        size_zero,
    input  logic        size_last
);
    localparam int LEN_BYTES  = LEN_W / BYTE_W;
    localparam int SIZE_BYTES = SIZE_W / BYTE_W;
    localparam int NUM_FIELDS = NUM_PLAIN + NUM_KEYED;
    localparam int MAXB       = (SIZE_BYTES > LEN_BYTES) ? SIZE_BYTES : LEN_BYTES;
    localparam int BIDX_W     = $clog2(MAXB) + 1;
    localparam int FIDX_W     = $clog2(NUM_FIELDS) + 1;

    step_t             step_q, step_d;
    logic [FIDX_W-1:0] fidx_q, fidx_d;
    logic [BIDX_W-1:0] bidx_q, bidx_d;
    logic              acc;
    logic [7:0]        exp_key;
    logic              fld_is_plain;
    logic              fld_is_final;

    // Handshake: header is always taken, payload follows downstream ready.
    always_comb begin
        unique case (step_q)
            ST_LEN, ST_BODY, ST_KEY, ST_SIZE: in_ready = 1'b1;
            ST_PAY:                            in_ready = out_ready;
            default:                           in_ready = 1'b0;
        endcase
    end

    // Key expected after the current field and position of that field.
    always_comb begin
        acc          = in_valid && in_ready;
        exp_key      = KEY_BASE + 8'(fidx_q) - 8'(NUM_PLAIN);
        fld_is_plain = (fidx_q < FIDX_W'(NUM_PLAIN));
        fld_is_final = (fidx_q == FIDX_W'(NUM_FIELDS - 1));
    end

    // Counter control strobes.
    always_comb begin
        len_shift  = acc && (step_q == ST_LEN);
        len_dec    = acc && (step_q == ST_BODY);
        size_shift = acc && (step_q == ST_SIZE);
        size_dec   = acc && (step_q == ST_PAY);
    end

    // Next-step selection for the walk.
    always_comb begin
        step_d = step_q;
        fidx_d = fidx_q;
        bidx_d = bidx_q;
        if (acc) begin
            unique case (step_q)
                ST_LEN: begin
                    if (bidx_q == BIDX_W'(LEN_BYTES - 1)) begin
                        bidx_d = '0;
                        if (!len_zero) begin
                            step_d = ST_BODY;
                        end else if (fld_is_plain) begin
                            fidx_d = fidx_q + FIDX_W'(1);
                        end else begin
                            step_d = ST_KEY;
                        end
                    end else begin
                        bidx_d = bidx_q + BIDX_W'(1);
                    end
                end
                ST_BODY: begin
                    if (len_last) begin
                        if (fld_is_plain) begin
                            fidx_d = fidx_q + FIDX_W'(1);
                            step_d = ST_LEN;
                        end else begin
                            step_d = ST_KEY;
                        end
                    end
                end
                ST_KEY: begin
                    if (in_byte != exp_key) begin
                        step_d = ST_ERR;
                    end else if (fld_is_final) begin
                        step_d = ST_SIZE;
                        bidx_d = '0;
                    end else begin
                        fidx_d = fidx_q + FIDX_W'(1);
                        step_d = ST_LEN;
                    end
                end
                ST_SIZE: begin
                    if (bidx_q == BIDX_W'(SIZE_BYTES - 1)) begin
                        bidx_d = '0;
                        step_d = size_zero ? ST_DONE : ST_PAY;
                    end else begin
                        bidx_d = bidx_q + BIDX_W'(1);
                    end
                end
                ST_PAY: begin
                    if (size_last) step_d = ST_DONE;
                end
                default: ;
            endcase
        end
    end

    // State registers of the walker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_LEN;
            fidx_q <= '0;
            bidx_q <= '0;
        end else begin
            step_q <= step_d;
            fidx_q <= fidx_d;
            bidx_q <= bidx_d;
        end
    end

    always_comb step = step_q;

    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_ERR) |=> (step_q == ST_ERR));

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_DONE) |=> (step_q == ST_DONE));

    a_r1_field_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fidx_q < FIDX_W'(NUM_FIELDS));

    a_r5_pay_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_q == ST_PAY) |-> ($past(step_q) == ST_SIZE));

endmodule

// File: rtl/cfg_hdr_strip.sv
// Module: top of the header stripper. Combines the walker with a field-length
// counter and a payload counter; payload is passed through combinationally.
// Assumes a byte-wide valid/ready stream on both sides.
module cfg_hdr_strip
    import cfg_hdr_strip_pkg::*;
#(
    parameter int         LEN_W     = 16,
    parameter int         SIZE_W    = 32,
    parameter int         NUM_PLAIN = 2,
    parameter int         NUM_KEYED = 4,
    parameter logic [7:0] KEY_BASE  = 8'h62
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    output logic [7:0] out_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       hdr_err,
    output logic       done
);
    step_t step;
    logic  len_shift, len_dec, len_zero, len_last;
    logic  size_shift, size_dec, size_zero, size_last;

    cfg_hdr_walker #(
        .LEN_W(LEN_W), .SIZE_W(SIZE_W), .NUM_PLAIN(NUM_PLAIN),
        .NUM_KEYED(NUM_KEYED), .KEY_BASE(KEY_BASE)
    ) walker_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_data),
        .out_ready(out_ready), .in_ready(in_ready), .step(step),
        .len_shift(len_shift), .len_dec(len_dec), .len_zero(len_zero),
        .len_last(len_last), .size_shift(size_shift), .size_dec(size_dec),
        .size_zero(size_zero), .size_last(size_last)
    );

    cfg_hdr_down_cnt #(.W(LEN_W)) len_cnt_i (
        .clk(clk), .rst_n(rst_n), .shift_en(len_shift), .dec_en(len_dec),
        .byte_in(in_data), .shift_zero(len_zero), .cnt_last(len_last)
    );

    cfg_hdr_down_cnt #(.W(SIZE_W)) size_cnt_i (
        .clk(clk), .rst_n(rst_n), .shift_en(size_shift), .dec_en(size_dec),
        .byte_in(in_data), .shift_zero(size_zero), .cnt_last(size_last)
    );

    // Payload pass-through and status flags from the walker step.
    always_comb begin
        out_data  = in_data;
        out_valid = in_valid && (step == ST_PAY);
        hdr_err   = (step == ST_ERR);
        done      = (step == ST_DONE);
    end

    a_r6_quiet_outside_payload: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!hdr_err && !done));

    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    a_r8_closed_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    a_r3_closed_after_err: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |-> (!in_ready && !out_valid));

endmodule

// File: tb/cfg_hdr_strip_tb_top.sv
module cfg_hdr_strip_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic       hdr_err;
    logic       done;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;

    logic [7:0] strm[$];
    logic [7:0] expq[$];
    logic [7:0] gotq[$];
    int hdr_end;

    always #2.5 clk = ~clk;

    cfg_hdr_strip dut_i (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .hdr_err(hdr_err), .done(done)
    );

    // Watchdog: a hung run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 150000 && !finished) begin
            errs = errs + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errs = errs + 1;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        out_ready = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Builds a stream: six fields, keys (one may be corrupted), count, payload.
    task automatic build(input int lens[6], input int bad_key, input int pay_n,
                         input int cnt_val);
        strm.delete();
        expq.delete();
        for (int f = 0; f < 6; f++) begin
            strm.push_back(8'(lens[f] >> 8));
            strm.push_back(8'(lens[f]));
            for (int b = 0; b < lens[f]; b++) strm.push_back(8'($urandom));
            if (f >= 2) begin
                if (f - 2 == bad_key) strm.push_back(8'h62 + 8'(f - 2) + 8'h10);
                else                  strm.push_back(8'h62 + 8'(f - 2));
                if (f - 2 == bad_key) return;
            end
        end
        for (int s = 3; s >= 0; s--) strm.push_back(8'(cnt_val >> (8 * s)));
        hdr_end = strm.size();
        for (int p = 0; p < pay_n; p++) begin
            logic [7:0] v;
            v = 8'($urandom);
            strm.push_back(v);
            expq.push_back(v);
        end
    endtask

    // Drives the stream with random gaps; checks ordering, stalls and flags.
    task automatic run(input int vpct, input int rpct, input bit exp_err, input string tag);
        int idx = 0;
        int early = 0;
        int stall_bad = 0;
        int n = 0;
        int mism = 0;
        gotq.delete();
        while (idx < strm.size() && n < 20000 && !hdr_err) begin
            @(negedge clk);
            in_valid  = ($urandom % 100) < vpct;
            in_data   = strm[idx];
            out_ready = ($urandom % 100) < rpct;
            #1;
            if (out_valid && idx < hdr_end) early++;
            if (out_valid && !out_ready && in_ready) stall_bad++;
            if (out_valid && out_ready) gotq.push_back(out_data);
            if (in_valid && in_ready) idx++;
            n++;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'hA5;
        out_ready = 1'b1;
        #1;
        chk(n < 20000, tag, "run finished in bound", n, 20000);
        chk(early == 0, "R6", {tag, " no output during header"}, early, 0);
        chk(stall_bad == 0, "R7", {tag, " held while stalled"}, stall_bad, 0);
        chk(hdr_err == exp_err, "R3", {tag, " hdr_err"}, hdr_err, exp_err);
        chk(done == !exp_err, "R8", {tag, " done after last byte"}, done, !exp_err);
        chk(!in_ready && !out_valid, "R8", {tag, " closed after end"}, in_ready, 0);
        chk(gotq.size() == expq.size(), "R5", {tag, " payload count"}, gotq.size(), expq.size());
        for (int i = 0; i < gotq.size() && i < expq.size(); i++)
            if (gotq[i] != expq[i]) mism++;
        chk(mism == 0, "R5", {tag, " payload bytes"}, mism, 0);
        if (exp_err) chk(idx == strm.size(), "R3", {tag, " stop right after bad key"}, idx, strm.size());
        in_valid = 1'b0;
    endtask

    initial begin
        int lens[6];
        void'($urandom(32'd2024));
        do_reset();
        #1;
        // R10: reset state
        chk(in_ready && !out_valid && !done && !hdr_err, "R10", "reset state",
            {in_ready, out_valid, done, hdr_err}, 4'b1000);

        // R1 directed: mixed field lengths, full throughput
        lens = '{3, 1, 5, 2, 4, 1};
        build(lens, -1, 10, 10);
        run(100, 100, 0, "R1");

        // R2: every field empty, downstream half ready
        do_reset();
        lens = '{0, 0, 0, 0, 0, 0};
        build(lens, -1, 7, 7);
        run(100, 50, 0, "R2");

        // R1/R4: long field uses the high length byte, count uses two bytes
        do_reset();
        lens = '{300, 0, 2, 0, 1, 0};
        build(lens, -1, 261, 261);
        run(80, 70, 0, "R4");

        // R9: zero payload count
        do_reset();
        lens = '{1, 2, 3, 0, 0, 1};
        build(lens, -1, 0, 0);
        run(100, 100, 0, "R9");

        // R3: third key wrong, then first key wrong
        do_reset();
        lens = '{1, 1, 1, 1, 1, 1};
        build(lens, 2, 0, 0);
        run(100, 100, 1, "R3");
        do_reset();
        lens = '{0, 4, 2, 2, 2, 2};
        build(lens, 0, 0, 0);
        run(60, 100, 1, "R3");

        // R7: heavy backpressure
        do_reset();
        lens = '{2, 2, 2, 2, 2, 2};
        build(lens, -1, 30, 30);
        run(100, 20, 0, "R7");

        // Random mixes
        for (int k = 0; k < 6; k++) begin
            int pn;
            do_reset();
            for (int f = 0; f < 6; f++) lens[f] = ($urandom % 4 == 0) ? 0 : int'($urandom % 20);
            pn = int'($urandom % 50);
            build(lens, -1, pn, pn);
            run(30 + int'($urandom % 70), 30 + int'($urandom % 70), 0, "R5");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule